// File: doc/BRIEF.md
# Selectable Video Test Pattern Generator

This block sits between a free-running raster timing source and the porch/sync stage of a video output. It receives two active-window flags, one high while the raster is inside the visible columns and one high while it is inside the visible rows. From the edges of these flags it rebuilds its own column and row position, so it needs no counter inputs. It then paints red, green and blue pixel values from that position according to a selectable pattern.

The pattern is picked by a 4-bit index taken from the low nibble of a received serial byte, captured on the byte's one-cycle valid strobe. The two flags are forwarded through a delay that matches the colour pipeline exactly, so the downstream stage sees flags and colour that belong to the same pixel. Channels are 3 bits wide, most significant bit first. Full intensity is 111 and half intensity is 100.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is asserted and until the first active pixel has passed the pipeline after reset, both forwarded flags and all three colour channels are 0.
- R2: The forwarded horizontal and vertical flags equal the input flags delayed by exactly 2 clock cycles, which is the same latency as the colour data.
- R3: The column position is 0 in the cycle where the horizontal flag rises and advances by one each cycle after. The row position is 0 in the cycle where the vertical flag rises and advances by one at each later rising edge of the horizontal flag. The colour output depends only on these positions, not on how long the blanking intervals last.
- R4: The pattern index is loaded from bits 3:0 of the byte input in a cycle where the valid strobe is 1. Bits 7:4 of that byte have no effect, and byte values presented while the strobe is 0 have no effect.
- R5: Whenever the forwarded flags are not both 1, all colour channels are 000.
- R6: Index 0 gives black (all channels 000). Index 1 gives red 111 with green and blue 000. Index 2 gives green only at 111. Index 3 gives blue only at 111.
- R7: Index 4 gives a checkerboard of square cells, each 2^SQ_LOG2 pixels on a side (32 by default). The cell holding column 0, row 0 is white (all channels 111). A cell whose column-cell and row-cell numbers differ in parity is half grey (all channels 100). Every channel value produced by any pattern is 000, 100 or 111.
- R8: Index 5 gives eight vertical bands, each ACTIVE_COLS/8 columns wide. For band number b (0 to 7, counted from column 0), red is 111 when b bit 1 is 0, green is 111 when b bit 2 is 0, and blue is 111 when b bit 0 is 0; otherwise the channel is 000. Band 0 is white and band 7 is black.
- R9: Index 6 gives white (all 111) on column 0, column ACTIVE_COLS-1, row 0 and row ACTIVE_ROWS-1 of the active area, and black everywhere inside.
- R10: Indices 7 to 15 give black.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_active_in | input | 1 | High while the raster is inside the visible columns |
| v_active_in | input | 1 | High while the raster is inside the visible rows |
| sel_valid | input | 1 | One-cycle strobe marking a received selection byte |
| sel_byte | input | 8 | Received byte; bits 3:0 carry the pattern index |
| h_active_out | output | 1 | Horizontal flag aligned with the colour outputs |
| v_active_out | output | 1 | Vertical flag aligned with the colour outputs |
| red | output | CHAN_W | Red channel, MSB first |
| green | output | CHAN_W | Green channel, MSB first |
| blue | output | CHAN_W | Blue channel, MSB first |

## Verification
Whole frames are driven with each index, and every output cycle is compared against a pixel model. The solid colours show whether the channels are routed correctly. The bars show whether the band counter and its bit-to-channel mapping are right. The checkerboard separates column bits from row bits, and the border catches off-by-one errors at both ends of each axis. The frames use different horizontal and vertical blanking lengths, and one frame is preceded by a runt horizontal pulse, which shows that position comes from flag edges and not from fixed totals. Byte sequences with set high nibbles and bytes presented without the strobe show that only strobed low nibbles select the pattern.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // Pattern index encodings; anything not listed paints black.
    localparam logic [3:0] IDX_BLACK   = 4'd0;
    localparam logic [3:0] IDX_RED     = 4'd1;
    localparam logic [3:0] IDX_GREEN   = 4'd2;
    localparam logic [3:0] IDX_BLUE    = 4'd3;
    localparam logic [3:0] IDX_CHECKER = 4'd4;
    localparam logic [3:0] IDX_BARS    = 4'd5;
    localparam logic [3:0] IDX_BORDER  = 4'd6;

    // Number of vertical bands and the width of the band number.
    localparam int NUM_BANDS = 8;
    localparam int BAND_W    = 3;

    // Clocks from flag input to colour/flag output.
    localparam int PIPE_LAT  = 2;

endpackage

// File: rtl/tpg_position.sv
// Stage 1: rebuild raster position from edges of the active-window flags.
module tpg_position #(
    parameter int ACTIVE_COLS = 640,
    parameter int TOTAL_COLS  = 800,
    parameter int TOTAL_ROWS  = 525,
    localparam int COL_W      = $clog2(TOTAL_COLS + 1),
    localparam int ROW_W      = $clog2(TOTAL_ROWS + 1),
    localparam int BAR_PIX    = ACTIVE_COLS / tpg_pkg::NUM_BANDS,
    localparam int BARC_W     = $clog2(BAR_PIX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      h_in,
    input  logic                      v_in,
    output logic [COL_W-1:0]          col,
    output logic [ROW_W-1:0]          row,
    output logic [tpg_pkg::BAND_W-1:0] band,
    output logic                      act
);
    localparam logic [BARC_W-1:0] BAR_LAST = BARC_W'(BAR_PIX - 1);
    localparam logic [tpg_pkg::BAND_W-1:0] BAND_LAST = tpg_pkg::BAND_W'(tpg_pkg::NUM_BANDS - 1);

    typedef struct packed {
        logic [COL_W-1:0]           col;
        logic [ROW_W-1:0]           row;
        logic [BARC_W-1:0]          bar_cnt;
        logic [tpg_pkg::BAND_W-1:0] band;
        logic                       h_prev;
        logic                       v_prev;
        logic                       act;
    } pos_t;

    pos_t pos_d, pos_q;
    logic h_rise, v_rise;

    always_comb begin
        pos_d  = pos_q;
        h_rise = h_in && !pos_q.h_prev;
        v_rise = v_in && !pos_q.v_prev;

        // Column and band tracking.
        if (h_rise) begin
            pos_d.col     = '0;
            pos_d.bar_cnt = '0;
            pos_d.band    = '0;
        end else begin
            if (pos_q.col != '1) begin
                pos_d.col = pos_q.col + 1'b1;
            end
            if (pos_q.bar_cnt == BAR_LAST) begin
                pos_d.bar_cnt = '0;
                if (pos_q.band != BAND_LAST) begin
                    pos_d.band = pos_q.band + 1'b1;
                end
            end else begin
                pos_d.bar_cnt = pos_q.bar_cnt + 1'b1;
            end
        end

        // Row tracking: restart on frame, advance on each new line.
        if (v_rise) begin
            pos_d.row = '0;
        end else if (h_rise && (pos_q.row != '1)) begin
            pos_d.row = pos_q.row + 1'b1;
        end

        pos_d.h_prev = h_in;
        pos_d.v_prev = v_in;
        pos_d.act    = h_in && v_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign col  = pos_q.col;
    assign row  = pos_q.row;
    assign band = pos_q.band;
    assign act  = pos_q.act;

endmodule

// File: rtl/tpg_colour.sv
// Stage 2: map position and pattern index to registered pixel colour.
module tpg_colour #(
    parameter int CHAN_W      = 3,
    parameter int ACTIVE_COLS = 640,
    parameter int ACTIVE_ROWS = 480,
    parameter int COL_W       = 10,
    parameter int ROW_W       = 10,
    parameter int SQ_LOG2     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  pattern,
    input  logic [COL_W-1:0]            col,
    input  logic [ROW_W-1:0]            row,
    input  logic [tpg_pkg::BAND_W-1:0]  band,
    input  logic                        act,
    output logic [CHAN_W-1:0]           red,
    output logic [CHAN_W-1:0]           green,
    output logic [CHAN_W-1:0]           blue
);
    import tpg_pkg::*;

    localparam logic [CHAN_W-1:0] FULL = '1;
    localparam logic [CHAN_W-1:0] HALF = {1'b1, {(CHAN_W-1){1'b0}}};
    localparam logic [COL_W-1:0]  LAST_COL = COL_W'(ACTIVE_COLS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(ACTIVE_ROWS - 1);

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } pix_t;

    pix_t pix_d, pix_q;
    logic odd_cell;
    logic on_edge;

    always_comb begin
        pix_d    = '0;
        odd_cell = col[SQ_LOG2] ^ row[SQ_LOG2];
        on_edge  = (col == '0) || (col == LAST_COL) ||
                   (row == '0) || (row == LAST_ROW);
        if (act) begin
            case (pattern)
                IDX_RED:   pix_d.r = FULL;
                IDX_GREEN: pix_d.g = FULL;
                IDX_BLUE:  pix_d.b = FULL;
                IDX_CHECKER: begin
                    pix_d.r = odd_cell ? HALF : FULL;
                    pix_d.g = odd_cell ? HALF : FULL;
                    pix_d.b = odd_cell ? HALF : FULL;
                end
                IDX_BARS: begin
                    pix_d.r = band[1] ? '0 : FULL;
                    pix_d.g = band[2] ? '0 : FULL;
                    pix_d.b = band[0] ? '0 : FULL;
                end
                IDX_BORDER: begin
                    if (on_edge) begin
                        pix_d.r = FULL;
                        pix_d.g = FULL;
                        pix_d.b = FULL;
                    end
                end
                default: pix_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign red   = pix_q.r;
    assign green = pix_q.g;
    assign blue  = pix_q.b;

endmodule

// File: rtl/tpg_flag_delay.sv
// Delays both active-window flags by DEPTH clocks.
module tpg_flag_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_in,
    input  logic v_in,
    output logic h_out,
    output logic v_out
);
    logic [DEPTH-1:0] hs_d, hs_q;
    logic [DEPTH-1:0] vs_d, vs_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                hs_d = h_in;
                vs_d = v_in;
            end
        end else begin : g_chain
            always_comb begin
                hs_d = {hs_q[DEPTH-2:0], h_in};
                vs_d = {vs_q[DEPTH-2:0], v_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '0;
            vs_q <= '0;
        end else begin
            hs_q <= hs_d;
            vs_q <= vs_d;
        end
    end

    assign h_out = hs_q[DEPTH-1];
    assign v_out = vs_q[DEPTH-1];

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
    parameter int CHAN_W      = 3,
    parameter int ACTIVE_COLS = 640,
    parameter int ACTIVE_ROWS = 480,
    parameter int TOTAL_COLS  = 800,
    parameter int TOTAL_ROWS  = 525,
    parameter int SQ_LOG2     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_active_in,
    input  logic              v_active_in,
    input  logic              sel_valid,
    input  logic [7:0]        sel_byte,
    output logic              h_active_out,
    output logic              v_active_out,
    output logic [CHAN_W-1:0] red,
    output logic [CHAN_W-1:0] green,
    output logic [CHAN_W-1:0] blue
);
    localparam int COL_W = $clog2(TOTAL_COLS + 1);
    localparam int ROW_W = $clog2(TOTAL_ROWS + 1);

    logic [3:0] pat_d, pat_q;
    logic       unused_sel_high;

    // Only the low nibble selects a pattern.
    assign unused_sel_high = ^sel_byte[7:4];

    always_comb begin
        pat_d = pat_q;
        if (sel_valid) begin
            pat_d = sel_byte[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else begin
            pat_q <= pat_d;
        end
    end

    logic [COL_W-1:0]           pos_col;
    logic [ROW_W-1:0]           pos_row;
    logic [tpg_pkg::BAND_W-1:0] pos_band;
    logic                       pos_act;

    tpg_position #(
        .ACTIVE_COLS (ACTIVE_COLS),
        .TOTAL_COLS  (TOTAL_COLS),
        .TOTAL_ROWS  (TOTAL_ROWS)
    ) u_position (
        .clk   (clk),
        .rst_n (rst_n),
        .h_in  (h_active_in),
        .v_in  (v_active_in),
        .col   (pos_col),
        .row   (pos_row),
        .band  (pos_band),
        .act   (pos_act)
    );

    tpg_colour #(
        .CHAN_W      (CHAN_W),
        .ACTIVE_COLS (ACTIVE_COLS),
        .ACTIVE_ROWS (ACTIVE_ROWS),
        .COL_W       (COL_W),
        .ROW_W       (ROW_W),
        .SQ_LOG2     (SQ_LOG2)
    ) u_colour (
        .clk     (clk),
        .rst_n   (rst_n),
        .pattern (pat_q),
        .col     (pos_col),
        .row     (pos_row),
        .band    (pos_band),
        .act     (pos_act),
        .red     (red),
        .green   (green),
        .blue    (blue)
    );

    tpg_flag_delay #(
        .DEPTH (tpg_pkg::PIPE_LAT)
    ) u_flag_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .h_in  (h_active_in),
        .v_in  (v_active_in),
        .h_out (h_active_out),
        .v_out (v_active_out)
    );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_in,
    input logic              v_in,
    input logic              sel_valid,
    input logic [7:0]        sel_byte,
    input logic [3:0]        pat,
    input logic              h_out,
    input logic              v_out,
    input logic [CHAN_W-1:0] red,
    input logic [CHAN_W-1:0] green,
    input logic [CHAN_W-1:0] blue
);
    localparam logic [CHAN_W-1:0] FULL = '1;
    localparam logic [CHAN_W-1:0] HALF = {1'b1, {(CHAN_W-1){1'b0}}};

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    function automatic logic legal_level(input logic [CHAN_W-1:0] c);
        return (c == '0) || (c == FULL) || (c == HALF);
    endfunction

    assert_flag_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (h_out == $past(h_in, 2)) && (v_out == $past(v_in, 2)));

    assert_index_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> (pat == $past(sel_byte[3:0])));

    assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> $stable(pat));

    assert_blank_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_out && v_out) |-> (red == '0) && (green == '0) && (blue == '0));

    assert_solid_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_out && v_out && ($past(pat) == 4'd1)) |->
            (red == FULL) && (green == '0) && (blue == '0));

    assert_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        legal_level(red) && legal_level(green) && legal_level(blue));

    assert_unused_black_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pat) >= 4'd7) |-> (red == '0) && (green == '0) && (blue == '0));

endmodule

bind test_pattern_gen tpg_checker #(.CHAN_W(CHAN_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_in      (h_active_in),
    .v_in      (v_active_in),
    .sel_valid (sel_valid),
    .sel_byte  (sel_byte),
    .pat       (pat_q),
    .h_out     (h_active_out),
    .v_out     (v_active_out),
    .red       (red),
    .green     (green),
    .blue      (blue)
);

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;
    localparam int CW = 3;
    localparam int AC = 64;
    localparam int AR = 12;
    localparam int TC = 96;
    localparam int TR = 16;
    localparam int SQ = 2;
    localparam int BARW = AC / 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          h_in = 1'b0, v_in = 1'b0;
    logic          sel_valid = 1'b0;
    logic [7:0]    sel_byte = 8'h00;
    logic          h_out, v_out;
    logic [CW-1:0] red, green, blue;

    test_pattern_gen #(
        .CHAN_W(CW), .ACTIVE_COLS(AC), .ACTIVE_ROWS(AR),
        .TOTAL_COLS(TC), .TOTAL_ROWS(TR), .SQ_LOG2(SQ)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .h_active_in(h_in), .v_active_in(v_in),
        .sel_valid(sel_valid), .sel_byte(sel_byte),
        .h_active_out(h_out), .v_active_out(v_out),
        .red(red), .green(green), .blue(blue)
    );

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    logic [3:0]  model_pat = 4'd0;
    logic [10:0] pipe0, pipe1;
    bit    pv0 = 1'b0, pv1 = 1'b0;
    string tag0, tag1, force_tag = "";
    logic  nxt_valid = 1'b0;
    logic [7:0] nxt_byte = 8'h00;

    function automatic string tag_for(input logic [3:0] p, input logic act);
        if (force_tag != "") return force_tag;
        if (!act) return "R5";
        case (p)
            4'd0, 4'd1, 4'd2, 4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R8";
            4'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Expected {r,g,b} from the requirements.
    function automatic logic [8:0] model_rgb(input logic [3:0] p, input int x, input int y,
                                             input logic act);
        int b;
        if (!act) return 9'h000;
        case (p)
            4'd1: return 9'b111_000_000;
            4'd2: return 9'b000_111_000;
            4'd3: return 9'b000_000_111;
            4'd4: return ((((x >> SQ) + (y >> SQ)) % 2) == 0) ? 9'b111_111_111 : 9'b100_100_100;
            4'd5: begin
                b = x / BARW;
                return {(b & 2) ? 3'b000 : 3'b111, (b & 4) ? 3'b000 : 3'b111,
                        (b & 1) ? 3'b000 : 3'b111};
            end
            4'd6: return (x == 0 || x == AC - 1 || y == 0 || y == AR - 1) ? 9'h1FF : 9'h000;
            default: return 9'h000;
        endcase
    endfunction

    task automatic check(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // One pixel clock: check output for input two cycles back, then drive new input.
    task automatic px(input logic h, input logic v, input int x, input int y);
        @(negedge clk);
        if (pv1) begin
            check("R2", "flags", {h_out, v_out}, pipe1[10:9]);
            check(tag1, "colour", {red, green, blue}, pipe1[8:0]);
        end
        pipe1 = pipe0; pv1 = pv0; tag1 = tag0;
        pipe0 = {h, v, model_rgb(model_pat, x, y, h && v)};
        tag0  = tag_for(model_pat, h && v);
        pv0   = 1'b1;
        h_in = h; v_in = v;
        sel_valid = nxt_valid; sel_byte = nxt_byte;
        if (nxt_valid) model_pat = nxt_byte[3:0];
        nxt_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) px(1'b0, 1'b0, 0, 0);
    endtask

    task automatic frame(input int hblank, input int vblank);
        for (int y = 0; y < AR + vblank; y++)
            for (int x = 0; x < AC + hblank; x++)
                px(x < AC, y < AR, x, y);
        idle(3);
    endtask

    task automatic send_byte(input logic [7:0] b);
        nxt_valid = 1'b1; nxt_byte = b;
        idle(1);
        idle(2);
    endtask

    task automatic t_reset;
        // R1: outputs quiet during and right after reset
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        h_in = 1'b1; v_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "flags in reset", {h_out, v_out}, 0);
        check("R1", "colour in reset", {red, green, blue}, 0);
        h_in = 1'b0; v_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", {h_out, v_out}, 0);
        check("R1", "colour after reset", {red, green, blue}, 0);
        idle(4);
    endtask

    task automatic t_solid;
        for (int p = 0; p < 4; p++) begin
            send_byte(8'(p));
            frame(16, 2); // R6
        end
    endtask

    task automatic t_checker;
        send_byte(8'h04);
        frame(20, 3); // R7
    endtask

    task automatic t_bars;
        send_byte(8'h05);
        frame(10, 2); // R8
    endtask

    task automatic t_border;
        send_byte(8'h06);
        frame(12, 2); // R9
    endtask

    task automatic t_unused;
        send_byte(8'h07);
        frame(8, 1); // R10
        send_byte(8'h0F);
        frame(8, 1); // R10
    endtask

    task automatic t_index_latch;
        // R4: high nibble ignored, unstrobed bytes ignored
        force_tag = "R4";
        send_byte(8'hA5);
        frame(16, 2);
        nxt_byte = 8'h02;
        idle(3);
        frame(16, 2);
        send_byte(8'hF6);
        frame(16, 2);
        force_tag = "";
    endtask

    task automatic t_resync;
        // R3: runt line while vertical flag low, then frames with odd blanking
        force_tag = "R3";
        send_byte(8'h04);
        for (int i = 0; i < 5; i++) px(1'b1, 1'b0, i, 0);
        idle(7);
        frame(3, 1);
        send_byte(8'h06);
        frame(29, 4);
        force_tag = "";
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_solid();
        t_checker();
        t_bars();
        t_border();
        t_unused();
        t_index_latch();
        t_resync();
        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule